// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Macrocell

This block is a single output slice of a small programmable-logic array. A set of input literals is formed from the array inputs plus one feedback signal, in true and complemented form. Configuration bits pick, per product term, which literals take part in an AND. A fixed OR gate sums the product terms. The resulting sum drives an output cell that can run in one of four ways: a dedicated input with the driver off, an always-driven combinational output, a combinational output gated by a product-term enable, or a registered output.

Two global mode bits, shared by every slice of the array, and one local mode bit select the cell's behaviour. A polarity bit picks active-high or active-low output. The output register clears on reset. It can also be forced to any value through a preload path, which is used for test. All configuration is held in flops and is loaded through a parallel port while the cell is idle.

Top module: `sop_macrocell`

## Requirements
- R1: Literal k of the array is `in_lits[k]` for k < NUM_IN, and the feedback signal for k = NUM_IN. For product term p, bit `p*2*NUM_LIT + 2*k` of `cfg_and` selects literal k in true form, and bit `p*2*NUM_LIT + 2*k + 1` selects its complement. A term is the AND of its selected literals. A term with no literal selected is 1.
- R2: The logic sum is the OR of all NUM_PT product terms, except in the product-term-enable kind, where term 0 is left out of the sum.
- R3: The cell kind is decoded from `cfg_gmode` and `cfg_lmode` as follows. gmode 10 gives the input kind when lmode is 1 and the always-on combinational kind when lmode is 0. gmode 11 gives the product-term-enable combinational kind. gmode 01 gives the product-term-enable kind when lmode is 1 and the registered kind when lmode is 0.
- R4: With `cfg_pol` = 1 the polarity-adjusted sum equals the sum; with `cfg_pol` = 0 it is the complement. In every non-registered kind, `pad_out` carries the polarity-adjusted sum.
- R5: In the registered kind, the register loads the polarity-adjusted sum at each rising clock edge. `pad_out` shows the register, `pad_oe` equals `!oe_n`, and `fb_out` is the inverted register value.
- R6: In the product-term-enable kind, `pad_oe` equals product term 0.
- R7: The input kind holds `pad_oe` at 0. The always-on combinational kind holds `pad_oe` at 1.
- R8: In every kind other than registered, `fb_out` equals `pad_in`.
- R9: When `preload_en` is 1 at a rising edge, the register loads `preload_val`, whatever the kind and the sum.
- R10: Reset clears the register to 0. It also returns the configuration to the input kind, with pol 1 and every `cfg_and` bit set, so every product term is 0.
- R11: When `cfg_we` is 1 at a rising edge, the configuration inputs are stored and take effect from that edge. When `cfg_we` is 0, changes on those inputs have no effect.
- R12: The unused global combination gmode 00 behaves as the input kind.
- R13: Outside the registered kind, and with no preload, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_lits | input | NUM_IN | Array inputs |
| pad_in | input | 1 | Level seen on the output pin |
| oe_n | input | 1 | Shared active-low enable for registered cells |
| preload_en | input | 1 | Force the register from `preload_val` |
| preload_val | input | 1 | Value to preload |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_gmode | input | 2 | Global mode bits |
| cfg_lmode | input | 1 | Local mode bit |
| cfg_pol | input | 1 | 1 = active-high output |
| cfg_and | input | NUM_PT*2*(NUM_IN+1) | Literal selection bits for all terms |
| pad_out | output | 1 | Output data to the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback literal returned to the array |

## Verification
The bench builds the block with NUM_IN = 4 and NUM_PT = 8. The narrower literal set means that sparse random masks often produce product terms that evaluate true. With all eight terms kept, the removal of term 0 from the sum in the product-term-enable kind stays visible. The bench also sweeps every combination of the three mode bits and the polarity bit, including the unused one, while a reference model tracks the register across mode changes and preloads.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

  typedef enum logic [1:0] {
    KIND_INPUT   = 2'd0,
    KIND_COMB_ON = 2'd1,
    KIND_COMB_PT = 2'd2,
    KIND_REG     = 2'd3
  } cell_kind_e;

  typedef struct packed {
    logic [1:0] gmode;
    logic       lmode;
    logic       pol_high;
  } cell_mode_t;

  localparam cell_mode_t MODE_RESET = '{gmode: 2'b10, lmode: 1'b1, pol_high: 1'b1};

  function automatic cell_kind_e decode_kind(input logic [1:0] gmode, input logic lmode);
    cell_kind_e k;
    unique case (gmode)
      2'b10:   k = lmode ? KIND_INPUT : KIND_COMB_ON;
      2'b11:   k = KIND_COMB_PT;
      2'b01:   k = lmode ? KIND_COMB_PT : KIND_REG;
      default: k = KIND_INPUT;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
  import sop_cell_pkg::*;
#(
  parameter int CFG_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  cell_mode_t            mode_in,
  input  logic [CFG_W-1:0]      and_in,
  output cell_mode_t            mode_q,
  output logic [CFG_W-1:0]      and_q,
  output cell_kind_e            kind
);

  cell_mode_t         mode_d;
  logic [CFG_W-1:0]   and_d;

  always_comb begin
    mode_d = mode_q;
    and_d  = and_q;
    if (cfg_we) begin
      mode_d = mode_in;
      and_d  = and_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      and_q  <= '1;
    end else begin
      mode_q <= mode_d;
      and_q  <= and_d;
    end
  end

  assign kind = decode_kind(mode_q.gmode, mode_q.lmode);

endmodule

// File: rtl/sop_pt_array.sv
module sop_pt_array #(
  parameter int NUM_LIT = 9,
  parameter int NUM_PT  = 8
) (
  input  logic [NUM_LIT-1:0]          lits,
  input  logic [NUM_PT*2*NUM_LIT-1:0] and_cfg,
  output logic [NUM_PT-1:0]           pt
);

  localparam int TERM_W = 2 * NUM_LIT;

  for (genvar p = 0; p < NUM_PT; p++) begin : g_term
    logic [NUM_LIT-1:0] use_t;
    logic [NUM_LIT-1:0] use_c;
    for (genvar k = 0; k < NUM_LIT; k++) begin : g_lit
      assign use_t[k] = and_cfg[p*TERM_W + 2*k];
      assign use_c[k] = and_cfg[p*TERM_W + 2*k + 1];
    end
    // a literal that is not selected contributes a 1 to the AND
    assign pt[p] = &((~use_t | lits) & (~use_c | ~lits));
  end

endmodule

// File: rtl/sop_fb_mux.sv
module sop_fb_mux
  import sop_cell_pkg::*;
(
  input  cell_kind_e kind,
  input  logic       reg_q,
  input  logic       pad_in,
  output logic       fb
);

  always_comb begin
    if (kind == KIND_REG) fb = ~reg_q;
    else                  fb = pad_in;
  end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import sop_cell_pkg::*;
#(
  parameter int NUM_PT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cell_kind_e        kind,
  input  logic              pol_high,
  input  logic [NUM_PT-1:0] pt,
  input  logic              oe_n,
  input  logic              preload_en,
  input  logic              preload_val,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              reg_q
);

  logic [NUM_PT-1:0] sum_mask;
  logic              sum;
  logic              pol_val;
  logic              q_en;
  logic              q_next;

  // sum mux: term 0 is taken by the enable in the product-term-enable kind
  always_comb begin
    sum_mask = '1;
    if (kind == KIND_COMB_PT) sum_mask[0] = 1'b0;
    sum = |(pt & sum_mask);
  end

  // polarity mux
  assign pol_val = pol_high ? sum : ~sum;

  // next state and clock enable of the output register
  always_comb begin
    q_en   = preload_en | (kind == KIND_REG);
    q_next = preload_en ? preload_val : pol_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    reg_q <= 1'b0;
    else if (q_en) reg_q <= q_next;
  end

  // output data and enable muxes
  always_comb begin
    pad_out = (kind == KIND_REG) ? reg_q : pol_val;
    unique case (kind)
      KIND_INPUT:   pad_oe = 1'b0;
      KIND_COMB_ON: pad_oe = 1'b1;
      KIND_COMB_PT: pad_oe = pt[0];
      default:      pad_oe = ~oe_n;
    endcase
  end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_cell_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_PT = 8,
  localparam int NUM_LIT = NUM_IN + 1,
  localparam int CFG_W   = NUM_PT * 2 * NUM_LIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] in_lits,
  input  logic              pad_in,
  input  logic              oe_n,
  input  logic              preload_en,
  input  logic              preload_val,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_gmode,
  input  logic              cfg_lmode,
  input  logic              cfg_pol,
  input  logic [CFG_W-1:0]  cfg_and,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              fb_out
);

  logic [1:0]         rst_sync;
  logic               rst_core_n;
  cell_mode_t         mode_in;
  cell_mode_t         mode_q;
  logic [CFG_W-1:0]   and_q;
  cell_kind_e         cell_kind;
  logic [NUM_LIT-1:0] lits;
  logic [NUM_PT-1:0]  pt;
  logic               reg_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign mode_in = '{gmode: cfg_gmode, lmode: cfg_lmode, pol_high: cfg_pol};

  sop_cfg_store #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cfg_we  (cfg_we),
    .mode_in (mode_in),
    .and_in  (cfg_and),
    .mode_q  (mode_q),
    .and_q   (and_q),
    .kind    (cell_kind)
  );

  sop_fb_mux u_fb (
    .kind   (cell_kind),
    .reg_q  (reg_q),
    .pad_in (pad_in),
    .fb     (fb_out)
  );

  assign lits = {fb_out, in_lits};

  sop_pt_array #(.NUM_LIT(NUM_LIT), .NUM_PT(NUM_PT)) u_arr (
    .lits    (lits),
    .and_cfg (and_q),
    .pt      (pt)
  );

  sop_out_cell #(.NUM_PT(NUM_PT)) u_cell (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .kind        (cell_kind),
    .pol_high    (mode_q.pol_high),
    .pt          (pt),
    .oe_n        (oe_n),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .reg_q       (reg_q)
  );

endmodule

// File: rtl/sop_macrocell_chk.sv
module sop_macrocell_chk
  import sop_cell_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input cell_kind_e kind,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       fb_out,
  input logic       pad_in,
  input logic       oe_n,
  input logic       preload_en,
  input logic       preload_val,
  input logic       reg_q
);

  // R7
  input_kind_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_INPUT) |-> !pad_oe);

  // R5
  reg_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_REG) |-> (pad_oe == !oe_n));

  // R5
  reg_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_REG) |-> (fb_out == !pad_out));

  // R8
  pin_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != KIND_REG) |-> (fb_out == pad_in));

  // R9
  preload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> (reg_q == $past(preload_val)));

  // R13
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en && kind != KIND_REG) |=> $stable(reg_q));

endmodule

bind sop_macrocell sop_macrocell_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .kind        (cell_kind),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .fb_out      (fb_out),
  .pad_in      (pad_in),
  .oe_n        (oe_n),
  .preload_en  (preload_en),
  .preload_val (preload_val),
  .reg_q       (reg_q)
);

// File: tb/sop_macrocell_tb.sv
module sop_macrocell_tb;

  localparam int NI = 4;
  localparam int NP = 8;
  localparam int NL = NI + 1;
  localparam int TW = 2 * NL;
  localparam int CW = NP * TW;

  localparam logic [3:0] MD_INPUT  = 4'b10_1_1;
  localparam logic [3:0] MD_ON     = 4'b10_0_1;
  localparam logic [3:0] MD_PT     = 4'b11_0_1;
  localparam logic [3:0] MD_REG    = 4'b01_0_1;
  localparam logic [3:0] MD_REG_LO = 4'b01_0_0;
  localparam logic [3:0] MD_RSVD   = 4'b00_0_1;

  localparam logic [TW-1:0] T_ZERO = 10'b0000000011;
  localparam logic [TW-1:0] T_EMPTY = '0;
  localparam logic [TW-1:0] T_A_NB = 10'b0000001001;
  localparam logic [TW-1:0] T_IN0 = 10'b0000000001;
  localparam logic [TW-1:0] T_FB = 10'b0100000000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [NI-1:0] in_lits;
  logic          pad_in, oe_n, preload_en, preload_val, cfg_we;
  logic [1:0]    cfg_gmode;
  logic          cfg_lmode, cfg_pol;
  logic [CW-1:0] cfg_and;
  logic          pad_out, pad_oe, fb_out;

  sop_macrocell #(.NUM_IN(NI), .NUM_PT(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_lits(in_lits), .pad_in(pad_in), .oe_n(oe_n),
    .preload_en(preload_en), .preload_val(preload_val), .cfg_we(cfg_we),
    .cfg_gmode(cfg_gmode), .cfg_lmode(cfg_lmode), .cfg_pol(cfg_pol),
    .cfg_and(cfg_and), .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  typedef struct {
    logic  out;
    logic  oe;
    logic  fb;
    string req;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [3:0]    m_md;
  logic [CW-1:0] m_and;
  logic          m_q;

  // stimulus for the next cycle
  logic [NI-1:0] d_in;
  logic          d_pad, d_oen, d_pe, d_pv, d_we;
  logic [3:0]    d_md;
  logic [CW-1:0] d_am;

  function automatic logic ref_term(input logic [CW-1:0] a, input logic [NL-1:0] l, input int p);
    logic r = 1'b1;
    for (int k = 0; k < NL; k++) begin
      if (a[p*TW + 2*k] && !l[k])    r = 1'b0;
      if (a[p*TW + 2*k + 1] && l[k]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] put_term(input logic [CW-1:0] m, input int p, input logic [TW-1:0] t);
    m[p*TW +: TW] = t;
    return m;
  endfunction

  function automatic logic [CW-1:0] sparse_mask();
    logic [CW-1:0] m;
    for (int i = 0; i < CW; i++) m[i] = ($urandom % 4) == 0;
    return m;
  endfunction

  // driver: applies one cycle of stimulus, queues the expected outputs,
  // then advances the reference state at the rising edge
  task automatic cyc(input string req);
    int   kd;
    logic fbv, sum, pv_pol, eo, eoe;
    logic [NL-1:0] l;
    @(negedge clk);
    in_lits = d_in; pad_in = d_pad; oe_n = d_oen; preload_en = d_pe; preload_val = d_pv;
    cfg_we = d_we; {cfg_gmode, cfg_lmode, cfg_pol} = d_md; cfg_and = d_am;
    case (m_md[3:2])
      2'b10:   kd = m_md[1] ? 0 : 1;
      2'b11:   kd = 2;
      2'b01:   kd = m_md[1] ? 2 : 3;
      default: kd = 0;
    endcase
    fbv = (kd == 3) ? ~m_q : d_pad;
    l   = {fbv, d_in};
    sum = 1'b0;
    for (int p = 0; p < NP; p++)
      if (!(kd == 2 && p == 0)) sum = sum | ref_term(m_and, l, p);
    pv_pol = m_md[0] ? sum : ~sum;
    eo  = (kd == 3) ? m_q : pv_pol;
    eoe = (kd == 0) ? 1'b0 : (kd == 1) ? 1'b1 : (kd == 2) ? ref_term(m_and, l, 0) : ~d_oen;
    sbq.push_back('{eo, eoe, fbv, req});
    @(posedge clk);
    if (d_pe)         m_q = d_pv;
    else if (kd == 3) m_q = pv_pol;
    if (d_we) begin
      m_md  = d_md;
      m_and = d_am;
    end
    d_pe = 1'b0;
    d_we = 1'b0;
  endtask

  task automatic load(input logic [3:0] md, input logic [CW-1:0] am, input string req);
    d_md = md; d_am = am; d_we = 1'b1;
    cyc(req);
  endtask

  // monitor: compares the outputs against the queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (pad_out !== e.out || pad_oe !== e.oe || fb_out !== e.fb) begin
          fails++;
          $display("FAIL %s: out/oe/fb actual=%b%b%b expected=%b%b%b",
                   e.req, pad_out, pad_oe, fb_out, e.out, e.oe, e.fb);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] zero_all;
    zero_all = '1;
    m_md = 4'b1011; m_and = '1; m_q = 1'b0;
    d_in = '0; d_pad = 1'b0; d_oen = 1'b0; d_pe = 1'b0; d_pv = 1'b0; d_we = 1'b0;
    d_md = MD_INPUT; d_am = '1;
    rst_n = 1'b0;
    in_lits = '0; pad_in = 1'b0; oe_n = 1'b0; preload_en = 1'b0; preload_val = 1'b0;
    cfg_we = 1'b0; {cfg_gmode, cfg_lmode, cfg_pol} = MD_INPUT; cfg_and = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: reset configuration is the input kind with all terms zero
    d_pad = 1'b1; d_in = 4'hF; cyc("R10");
    d_pad = 1'b0; d_in = 4'h5; cyc("R10");

    // R11: load registered kind; R10: register reads zero after reset
    load(MD_REG, zero_all, "R11");
    d_oen = 1'b0; cyc("R10");
    d_oen = 1'b1; cyc("R5");
    d_oen = 1'b0;
    // R4: active-low registered output loads the complement of the sum
    load(MD_REG_LO, zero_all, "R4");
    cyc("R4");
    cyc("R4");
    // R9: preload overrides the next state
    d_pe = 1'b1; d_pv = 1'b0; cyc("R9");
    cyc("R9");
    d_pe = 1'b1; d_pv = 1'b1;
    load(MD_ON, put_term(zero_all, 1, T_A_NB), "R9");

    // R1: term 1 is in0 AND NOT in1
    d_in = 4'b0001; cyc("R1");
    d_in = 4'b0011; cyc("R1");
    d_in = 4'b0000; cyc("R1");
    d_in = 4'b0010; cyc("R1");
    // R13: register kept its preloaded value across combinational use
    load(MD_REG, zero_all, "R13");
    cyc("R13");

    // R1: a term with no literal selected is true
    load(MD_ON, put_term(zero_all, 2, T_EMPTY), "R1");
    d_in = 4'hA; cyc("R1");
    d_in = 4'h3; cyc("R1");

    // R2: term 0 is excluded from the sum in the enable kind
    load(MD_PT, put_term(zero_all, 0, T_EMPTY), "R2");
    cyc("R2");
    load(MD_PT, put_term(put_term(zero_all, 0, T_EMPTY), 3, T_EMPTY), "R2");
    cyc("R2");
    // R6: enable follows term 0 = in0
    load(MD_PT, put_term(zero_all, 0, T_IN0), "R6");
    d_in = 4'b0001; cyc("R6");
    d_in = 4'b0000; cyc("R6");

    // R8: combinational feedback comes from the pin
    load(MD_ON, put_term(zero_all, 1, T_FB), "R8");
    d_pad = 1'b1; cyc("R8");
    d_pad = 1'b0; cyc("R8");
    // R11: configuration inputs without the strobe have no effect
    d_md = MD_INPUT; d_am = '0; d_pad = 1'b1; cyc("R11");
    d_pad = 1'b0; cyc("R11");

    // R7 and R12
    load(MD_INPUT, zero_all, "R7");
    d_pad = 1'b1; cyc("R7");
    load(MD_ON, zero_all, "R7");
    cyc("R7");
    load(MD_RSVD, zero_all, "R12");
    d_pad = 1'b0; cyc("R12");
    d_pad = 1'b1; cyc("R12");

    // R3: every combination of mode and polarity bits with random terms
    for (int md = 0; md < 16; md++) begin
      load(4'(md), sparse_mask(), "R3");
      for (int v = 0; v < 12; v++) begin
        d_in = 4'($urandom); d_pad = 1'($urandom); d_oen = 1'($urandom);
        cyc("R3");
      end
    end

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule